// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses, at fetch time, whether a conditional branch will be taken. Two direction predictors work in parallel on every lookup. The global predictor keeps a table of 2-bit saturating counters. Its index is a shift register that holds the outcomes of the most recent branches. The local predictor has two levels. A per-branch table of outcome histories is read with low bits of the branch word address, and the history read out then indexes a table of 3-bit saturating counters. A third table of 2-bit counters is read with the branch address and decides, per branch, which of the two predictions becomes the final one.

The lookup is combinational. It returns the final guess, both component guesses, the global history value used and the local history value used. The fetch side keeps these as a snapshot and hands them back on the resolve port, together with the branch address and the real outcome. At resolution the global counter, the local counter, the local history entry, the global history and, where the two guesses differed, the selector entry are all trained in the same clock edge. Training uses the returned snapshot indices, so it reaches the same entries the lookup read even if other branches resolved in between.

Each selector entry is a four-state machine: SEL_STRONG_LOCAL, SEL_WEAK_LOCAL, SEL_WEAK_GLOBAL and SEL_STRONG_GLOBAL. A resolve in which the global guess alone was right moves the entry one step toward SEL_STRONG_GLOBAL. A resolve in which the local guess alone was right moves it one step toward SEL_STRONG_LOCAL. The two strong states hold when pushed further. Every other case leaves the state where it is.

Top module: `tourney_predictor`

## Requirements
- R1: After reset the global history and every local history are zero. Every global and selector counter is 1 and every local counter is 3. So the lookup gives pred_ghist=0, pred_lhist=0, pred_glob=0, pred_loc=0 and pred_taken=0 for any address.
- R2: The global counters have 2 bits and are read at index pred_ghist. pred_glob is 1 exactly when the counter value is 2 or more.
- R3: The local counters have 3 bits and are read at index pred_lhist. pred_loc is 1 exactly when the counter value is 4 or more.
- R4: Each resolve shifts the global history left by one place and puts res_taken into bit 0.
- R5: Each resolve shifts the local history entry at res_addr[9:0] the same way, with res_taken in bit 0. Entries at other addresses keep their value. pred_lhist is the entry at pred_addr[9:0].
- R6: The selector entry at pred_addr[11:0] chooses the final guess. A value of 2 or more chooses pred_glob. A value of 0 or 1 chooses pred_loc.
- R7: The selector entry at res_addr[11:0] changes only when res_glob and res_loc differ. It counts up when res_glob equals res_taken and counts down otherwise.
- R8: From a strong state (0 or 3), two resolves in a row that favour the other predictor are needed to change which predictor is chosen.
- R9: A resolve trains the global counter at res_ghist and the local counter at res_lhist, whatever the current history registers hold.
- R10: All counters count up on taken and down on not-taken. They stay at their maximum and at 0 rather than wrapping.
- R11: While res_valid is 0, no table or history changes, whatever the other res_* inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_addr | input | 12 | Low bits of the branch word address for the lookup |
| pred_taken | output | 1 | Final direction guess |
| pred_glob | output | 1 | Global predictor guess |
| pred_loc | output | 1 | Local predictor guess |
| pred_ghist | output | 12 | Global history used by the lookup (snapshot) |
| pred_lhist | output | 10 | Local history used by the lookup (snapshot) |
| res_valid | input | 1 | A resolved branch is presented this cycle |
| res_addr | input | 12 | Word address bits of the resolved branch |
| res_taken | input | 1 | Actual outcome |
| res_ghist | input | 12 | Global history snapshot from the lookup |
| res_lhist | input | 10 | Local history snapshot from the lookup |
| res_glob | input | 1 | Global guess snapshot |
| res_loc | input | 1 | Local guess snapshot |

## Verification
Four kinds of stimulus are used. A single branch with a repeating three-taken, one-not-taken loop pattern trains the local path and its 3-bit saturation. A strictly alternating branch shows the global and local guesses disagreeing and the selector moving between them. Many addresses whose outcomes follow recent global history exercise global indexing and selector state changes for each branch. A resolve with a snapshot that is out of date after other branches have resolved checks that training uses the returned indices, and idle cycles carrying junk resolve fields check that nothing moves while res_valid is low.

// File: rtl/tp_pkg.sv
package tp_pkg;

    // Which component prediction the selector hands to the output.
    typedef enum logic {
        PICK_LOCAL  = 1'b0,
        PICK_GLOBAL = 1'b1
    } pick_e;

    // Named states of one selector counter.
    typedef enum logic [1:0] {
        SEL_STRONG_LOCAL  = 2'd0,
        SEL_WEAK_LOCAL    = 2'd1,
        SEL_WEAK_GLOBAL   = 2'd2,
        SEL_STRONG_GLOBAL = 2'd3
    } sel_state_e;

endpackage

// File: rtl/tp_sat_table.sv
module tp_sat_table #(
    parameter int IDX_W = 12,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_upper,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up
);
    localparam int               DEPTH   = 1 << IDX_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_MIN = '0;
    localparam logic [CNT_W-1:0] WEAK_LO = CNT_MAX >> 1;

    logic [CNT_W-1:0] cnt [DEPTH];
    logic [CNT_W-1:0] cur;

    assign cur = cnt[wr_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cnt[i] <= WEAK_LO;
            end
        end else if (wr_en) begin
            if (wr_up && cur != CNT_MAX) begin
                cnt[wr_idx] <= cur + 1'b1;
            end else if (!wr_up && cur != CNT_MIN) begin
                cnt[wr_idx] <= cur - 1'b1;
            end
        end
    end

    // upper half of the range: top bit set
    assign rd_upper = cnt[rd_idx][CNT_W-1];

endmodule

// File: rtl/tp_hist_reg.sv
module tp_hist_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] hist
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (shift_en) begin
            hist <= {hist[W-2:0], bit_in};
        end
    end
endmodule

// File: rtl/tp_local_hist.sv
module tp_local_hist #(
    parameter int IDX_W  = 10,
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIST_W-1:0] rd_hist,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_bit
);
    localparam int DEPTH = 1 << IDX_W;

    logic [HIST_W-1:0] tbl [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tbl[i] <= '0;
            end
        end else if (wr_en) begin
            tbl[wr_idx] <= {tbl[wr_idx][HIST_W-2:0], wr_bit};
        end
    end

    assign rd_hist = tbl[rd_idx];
endmodule

// File: rtl/tourney_predictor.sv
module tourney_predictor #(
    parameter int GHIST_W   = 12,
    parameter int LHT_IDX_W = 10,
    parameter int LHIST_W   = 10,
    parameter int GCNT_W    = 2,
    parameter int LCNT_W    = 3,
    parameter int SCNT_W    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [GHIST_W-1:0] pred_addr,
    output logic               pred_taken,
    output logic               pred_glob,
    output logic               pred_loc,
    output logic [GHIST_W-1:0] pred_ghist,
    output logic [LHIST_W-1:0] pred_lhist,
    input  logic               res_valid,
    input  logic [GHIST_W-1:0] res_addr,
    input  logic               res_taken,
    input  logic [GHIST_W-1:0] res_ghist,
    input  logic [LHIST_W-1:0] res_lhist,
    input  logic               res_glob,
    input  logic               res_loc
);
    import tp_pkg::*;

    // selector and address share the global history width
    localparam int SEL_IDX_W = GHIST_W;

    logic  sel_upper;
    logic  sel_wr_en;
    logic  sel_wr_up;
    pick_e pick;

    tp_hist_reg #(.W(GHIST_W)) u_ghist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (res_valid),
        .bit_in   (res_taken),
        .hist     (pred_ghist)
    );

    tp_sat_table #(.IDX_W(GHIST_W), .CNT_W(GCNT_W)) u_gtab (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (pred_ghist),
        .rd_upper (pred_glob),
        .wr_en    (res_valid),
        .wr_idx   (res_ghist),
        .wr_up    (res_taken)
    );

    tp_local_hist #(.IDX_W(LHT_IDX_W), .HIST_W(LHIST_W)) u_lht (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (pred_addr[LHT_IDX_W-1:0]),
        .rd_hist (pred_lhist),
        .wr_en   (res_valid),
        .wr_idx  (res_addr[LHT_IDX_W-1:0]),
        .wr_bit  (res_taken)
    );

    tp_sat_table #(.IDX_W(LHIST_W), .CNT_W(LCNT_W)) u_ltab (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (pred_lhist),
        .rd_upper (pred_loc),
        .wr_en    (res_valid),
        .wr_idx   (res_lhist),
        .wr_up    (res_taken)
    );

    // Selector trains only on disagreement, toward the one that was right.
    assign sel_wr_en = res_valid && (res_glob != res_loc);
    assign sel_wr_up = (res_glob == res_taken);

    tp_sat_table #(.IDX_W(SEL_IDX_W), .CNT_W(SCNT_W)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (pred_addr),
        .rd_upper (sel_upper),
        .wr_en    (sel_wr_en),
        .wr_idx   (res_addr),
        .wr_up    (sel_wr_up)
    );

    assign pick = pick_e'(sel_upper);

    always_comb begin
        unique case (pick)
            PICK_GLOBAL: pred_taken = pred_glob;
            PICK_LOCAL:  pred_taken = pred_loc;
        endcase
    end

endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
    parameter int GHIST_W   = 12,
    parameter int LHT_IDX_W = 10,
    parameter int LHIST_W   = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic [GHIST_W-1:0] pred_addr,
    input logic               pred_taken,
    input logic               pred_glob,
    input logic               pred_loc,
    input logic [GHIST_W-1:0] pred_ghist,
    input logic [LHIST_W-1:0] pred_lhist,
    input logic               res_valid,
    input logic [GHIST_W-1:0] res_addr,
    input logic               res_taken
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        ($past(!rst_n) && rst_n) |-> (pred_ghist == '0));

    // R4
    ghist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> pred_ghist == {$past(pred_ghist[GHIST_W-2:0]), $past(res_taken)});

    // R11
    ghist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(pred_ghist));

    // R6
    agree_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_glob == pred_loc) |-> (pred_taken == pred_glob));

    // R5
    lhist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_addr[LHT_IDX_W-1:0] == pred_addr[LHT_IDX_W-1:0])
        |=> (pred_addr[LHT_IDX_W-1:0] != $past(pred_addr[LHT_IDX_W-1:0]))
            || (pred_lhist == {$past(pred_lhist[LHIST_W-2:0]), $past(res_taken)}));
endmodule

bind tourney_predictor tp_checker #(
    .GHIST_W   (GHIST_W),
    .LHT_IDX_W (LHT_IDX_W),
    .LHIST_W   (LHIST_W)
) u_tp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .pred_addr  (pred_addr),
    .pred_taken (pred_taken),
    .pred_glob  (pred_glob),
    .pred_loc   (pred_loc),
    .pred_ghist (pred_ghist),
    .pred_lhist (pred_lhist),
    .res_valid  (res_valid),
    .res_addr   (res_addr),
    .res_taken  (res_taken)
);

// File: tb/tourney_predictor_bench.sv
module tourney_predictor_bench;
    localparam int CLK_PERIOD = 10;
    localparam int GW   = 12;
    localparam int LIW  = 10;
    localparam int LHW  = 10;
    localparam int GN   = 1 << GW;
    localparam int LHN  = 1 << LIW;
    localparam int LCN  = 1 << LHW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [GW-1:0] pred_addr = '0;
    logic          pred_taken, pred_glob, pred_loc;
    logic [GW-1:0] pred_ghist;
    logic [LHW-1:0] pred_lhist;
    logic          res_valid = 1'b0;
    logic [GW-1:0] res_addr = '0;
    logic          res_taken = 1'b0;
    logic [GW-1:0] res_ghist = '0;
    logic [LHW-1:0] res_lhist = '0;
    logic          res_glob = 1'b0;
    logic          res_loc = 1'b0;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    int mg [GN];
    int ms [GN];
    int ml [LCN];
    int mh [LHN];
    int mgh;

    // last captured snapshot
    logic [GW-1:0]  sn_gh;
    logic [LHW-1:0] sn_lh;
    logic           sn_g, sn_l;

    always #(CLK_PERIOD/2) clk = ~clk;

    tourney_predictor u_tourney_predictor (
        .clk(clk), .rst_n(rst_n), .pred_addr(pred_addr),
        .pred_taken(pred_taken), .pred_glob(pred_glob), .pred_loc(pred_loc),
        .pred_ghist(pred_ghist), .pred_lhist(pred_lhist),
        .res_valid(res_valid), .res_addr(res_addr), .res_taken(res_taken),
        .res_ghist(res_ghist), .res_lhist(res_lhist),
        .res_glob(res_glob), .res_loc(res_loc)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < GN; i++) begin mg[i] = 1; ms[i] = 1; end
        for (int i = 0; i < LCN; i++) ml[i] = 3;
        for (int i = 0; i < LHN; i++) mh[i] = 0;
        mgh = 0;
    endtask

    function automatic int sat(int v, bit up, int mx);
        if (up) return (v < mx) ? v + 1 : v;
        return (v > 0) ? v - 1 : v;
    endfunction

    // One cycle: drive, compare against the reference, clock, update reference.
    task automatic cyc(input logic [GW-1:0] pa, input bit rv, input logic [GW-1:0] ra,
                       input bit rt, input logic [GW-1:0] rgh, input logic [LHW-1:0] rlh,
                       input bit rg, input bit rl);
        int lh, eg, el, et;
        pred_addr = pa; res_valid = rv; res_addr = ra; res_taken = rt;
        res_ghist = rgh; res_lhist = rlh; res_glob = rg; res_loc = rl;
        #1;
        lh = mh[int'(pa) % LHN];
        eg = (mg[mgh] >= 2) ? 1 : 0;        // R2
        el = (ml[lh] >= 4) ? 1 : 0;         // R3
        et = (ms[int'(pa)] >= 2) ? eg : el; // R6 R7 R8
        check("R4 pred_ghist", int'(pred_ghist), mgh);
        check("R5 pred_lhist", int'(pred_lhist), lh);
        check("R2 pred_glob", int'(pred_glob), eg);
        check("R3 pred_loc", int'(pred_loc), el);
        check("R6 pred_taken", int'(pred_taken), et);
        sn_gh = pred_ghist; sn_lh = pred_lhist; sn_g = pred_glob; sn_l = pred_loc;
        @(posedge clk);
        if (rv) begin
            // R9: train at the snapshot indices; R10: saturate
            mg[int'(rgh)] = sat(mg[int'(rgh)], rt, 3);
            ml[int'(rlh)] = sat(ml[int'(rlh)], rt, 7);
            if (rg != rl) ms[int'(ra)] = sat(ms[int'(ra)], (rg == rt), 3);
            mh[int'(ra) % LHN] = ((mh[int'(ra) % LHN] << 1) | int'(rt)) & (LCN - 1);
            mgh = ((mgh << 1) | int'(rt)) & (GN - 1);
        end
        @(negedge clk);
    endtask

    task automatic idle(input logic [GW-1:0] pa);
        cyc(pa, 1'b0, '0, 1'b0, '0, '0, 1'b0, 1'b0);
    endtask

    // look up, then resolve with the snapshot just taken
    task automatic branch(input logic [GW-1:0] a, input bit t);
        idle(a);
        cyc(a, 1'b1, a, t, sn_gh, sn_lh, sn_g, sn_l);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [GW-1:0]  old_gh;
        logic [LHW-1:0] old_lh;
        logic           old_g, old_l;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state through the lookup port
        pred_addr = 12'h123;
        #1;
        check("R1 pred_ghist", int'(pred_ghist), 0);
        check("R1 pred_lhist", int'(pred_lhist), 0);
        check("R1 pred_glob", int'(pred_glob), 0);
        check("R1 pred_loc", int'(pred_loc), 0);
        check("R1 pred_taken", int'(pred_taken), 0);
        @(negedge clk);

        // loop pattern on one branch: local path and R10 saturation
        for (int k = 0; k < 25; k++) begin
            branch(12'h005, 1'b1);
            branch(12'h005, 1'b1);
            branch(12'h005, 1'b1);
            branch(12'h005, 1'b0);
        end

        // alternating branch: disagreement drives the selector (R7, R8)
        for (int k = 0; k < 40; k++) branch(12'h2A0, k[0]);

        // outcomes tied to recent global history, many addresses
        for (int k = 0; k < 600; k++) begin
            logic [GW-1:0] a;
            a = GW'($urandom_range(0, 31) * 37);
            branch(a, mgh[1] ^ mgh[0]);
        end

        // R9: out-of-date snapshot still trains the entries it names
        idle(12'h0F0);
        old_gh = sn_gh; old_lh = sn_lh; old_g = sn_g; old_l = sn_l;
        branch(12'h111, 1'b1);
        branch(12'h222, 1'b0);
        cyc(12'h0F0, 1'b1, 12'h0F0, 1'b1, old_gh, old_lh, old_g, old_l);
        idle(12'h0F0);

        // R11: junk on the resolve fields with res_valid low changes nothing
        for (int k = 0; k < 20; k++) begin
            cyc(12'h0F0, 1'b0, 12'h0F0, 1'b1, pred_ghist, pred_lhist, 1'b0, 1'b1);
        end
        check("R11 ghist held", int'(pred_ghist), mgh);

        // R8: strong-global selector needs two local wins to flip
        for (int k = 0; k < 300; k++) branch(GW'($urandom_range(0, 4095)), ($urandom_range(0, 3) != 0));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule